// File: doc/BRIEF.md
# Host Parallel Port with DMA Handshake

This block sits between a host microprocessor bus and a coprocessor core. The host side has an 8-bit bidirectional data bus, a chip select, separate read and write strobes and one address line. Through these the host reaches a 16-bit data register and a read-only status byte. A DMA request output and an acknowledge input let a DMA controller move data into and out of the data register without address decoding.

The core loads the data register for the host to read, or takes the register's contents and invites the host to write a new value. Either action raises a request-for-master flag, which the core can test. A mode input chooses how the host moves the data register: as a single byte, which is the low byte, or as two bytes in a row, low byte first. The flag and the DMA request fall when the host finishes the last byte of the transfer. All host inputs are treated as synchronous to the block clock. A byte transfer takes effect on the clock edge where its strobe or select is first seen inactive.

Top module: `host_pport`

## Requirements
- R1: After reset the flag and DMA request are low, the data register is zero, the byte pointer is zero and the block does not drive the data bus.
- R2: A core load pulse stores the 16-bit core word, sets the flag and DMA request, and sets the direction bit to 1 (host should read).
- R3: In single-byte mode (mode input 0) a host read with the address line low returns data bits 7:0, and its completion clears the flag and DMA request.
- R4: In double-byte mode (mode input 1) the first host read returns bits 7:0 and leaves the flag set with the pointer bit at 1. The second read returns bits 15:8, then clears the flag and returns the pointer to 0.
- R5: In double-byte mode two host writes place the first byte in bits 7:0 and the second in bits 15:8. The flag clears only after the second write.
- R6: A core take pulse sets the flag and DMA request, clears the direction bit to 0 (host should write) and resets the byte pointer.
- R7: A host read with the address line high returns the status byte: bit 7 flag, bit 6 direction, bit 5 pointer not zero, bit 4 mode, bits 3:0 zero. Reading it and writing to that address change neither the data register, the flag nor the pointer.
- R8: While the DMA acknowledge (active low) is asserted, the data register is accessed whatever the chip select and address line are.
- R9: The block drives the bus only while the read strobe is low and either chip select or DMA acknowledge is asserted.
- R10: The DMA request equals the flag on every cycle. It falls only on the completion of the final byte of a transfer.
- R11: An access with both strobes low at once transfers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| a0 | input | 1 | Address: 0 data register, 1 status byte |
| dack_n | input | 1 | DMA acknowledge, active low, selects the data register |
| hd | inout | 8 | Host data bus |
| drq | output | 1 | DMA request |
| dual | input | 1 | Transfer mode: 0 one byte, 1 two bytes |
| core_wr | input | 1 | Core load pulse |
| core_wdata | input | 16 | Word loaded by the core |
| core_rd | input | 1 | Core take pulse |
| core_rdata | output | 16 | Current data register contents |
| rqm | output | 1 | Request-for-master flag |

## Verification
The assertions watch several rules on every cycle. The DMA request and the flag stay equal. The flag falls only after a completed final byte. A core load always leaves the flag and direction set. A first byte in double-byte mode never clears the flag. A status access never disturbs the data register, and the bus is released whenever the read strobe is high. The byte order in both modes, the status bit layout, the routing of accesses under DMA acknowledge and the tolerance of overlapping strobes can only be shown by the bench's scenarios, which compare the returned bytes and words with values worked out by hand.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int BUS_W = 8;
  localparam int DR_W  = 16;

  // Access target latched while a strobe is active.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DR   = 2'd1,
    TGT_SR   = 2'd2
  } tgt_e;

  // Status byte bit positions (decoded by host software).
  localparam int ST_RQM  = 7;
  localparam int ST_DIR  = 6;
  localparam int ST_PTR  = 5;
  localparam int ST_MODE = 4;
endpackage

// File: rtl/hpp_strobe.sv
module hpp_strobe
  import hpp_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         a0,
  input  logic         dack_n,
  input  logic [W-1:0] din,
  output logic         dr_rd_done,
  output logic         dr_wr_done,
  output logic         sr_done,
  output logic [W-1:0] wr_byte
);
  logic   sel_dr, sel_sr, one_strobe, cur_rd;
  tgt_e   cur_tgt;
  tgt_e   tgt_q, tgt_d;
  logic   rd_q, rd_d;
  logic [W-1:0] wdat_q, wdat_d;
  logic   acc_end;

  // Address decode: DMA acknowledge overrides chip select and address.
  always_comb begin
    sel_dr     = !dack_n || (!cs_n && !a0);
    sel_sr     = dack_n && !cs_n && a0;
    one_strobe = rd_n ^ wr_n;
    cur_rd     = !rd_n;
    if (!one_strobe)  cur_tgt = TGT_NONE;
    else if (sel_dr)  cur_tgt = TGT_DR;
    else if (sel_sr)  cur_tgt = TGT_SR;
    else              cur_tgt = TGT_NONE;
  end

  // Next state.
  always_comb begin
    tgt_d  = cur_tgt;
    rd_d   = cur_rd;
    wdat_d = wdat_q;
    if (cur_tgt == TGT_DR && !cur_rd) wdat_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= TGT_NONE;
      rd_q   <= 1'b0;
      wdat_q <= '0;
    end else begin
      tgt_q  <= tgt_d;
      rd_q   <= rd_d;
      wdat_q <= wdat_d;
    end
  end

  // An access completes when its target or direction is no longer seen.
  always_comb begin
    acc_end    = (tgt_q != TGT_NONE) && ((cur_tgt != tgt_q) || (cur_rd != rd_q));
    dr_rd_done = acc_end && (tgt_q == TGT_DR) && rd_q;
    dr_wr_done = acc_end && (tgt_q == TGT_DR) && !rd_q;
    sr_done    = acc_end && (tgt_q == TGT_SR);
    wr_byte    = wdat_q;
  end

  // R11: overlapping strobes never start an access that can complete.
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |=> !(dr_rd_done || dr_wr_done || sr_done));
endmodule

// File: rtl/hpp_dreg.sv
module hpp_dreg
  import hpp_pkg::*;
#(
  parameter int DW = DR_W,
  parameter int BW = BUS_W,
  localparam int NBYTE = DW / BW,
  localparam int PW    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic          core_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_rd,
  input  logic          rd_done,
  input  logic          wr_done,
  input  logic [BW-1:0] wr_byte,
  output logic [DW-1:0] dr,
  output logic [PW-1:0] idx,
  output logic          rqm,
  output logic          dir,
  output logic          fin
);
  localparam logic [PW-1:0] LAST = PW'(NBYTE - 1);

  logic [DW-1:0] dr_q, dr_d;
  logic [PW-1:0] idx_q, idx_d;
  logic          rqm_q, rqm_d;
  logic          dir_q, dir_d;
  logic          xfer;
  logic          dr_en;

  always_comb begin
    xfer = rd_done || wr_done;
    fin  = xfer && (!dual || (idx_q == LAST));
  end

  // Next state: core actions take priority over host byte completions.
  always_comb begin
    dr_d  = dr_q;
    idx_d = idx_q;
    rqm_d = rqm_q;
    dir_d = dir_q;
    dr_en = 1'b0;
    if (core_wr) begin
      dr_d  = core_wdata;
      dr_en = 1'b1;
      rqm_d = 1'b1;
      dir_d = 1'b1;
      idx_d = '0;
    end else if (core_rd) begin
      rqm_d = 1'b1;
      dir_d = 1'b0;
      idx_d = '0;
    end else if (xfer) begin
      if (wr_done) begin
        dr_en = 1'b1;
        dr_d[BW*int'(dual ? idx_q : '0) +: BW] = wr_byte;
      end
      if (fin) begin
        rqm_d = 1'b0;
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= '0;
    end else if (dr_en) begin
      dr_q <= dr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rqm_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      rqm_q <= rqm_d;
      dir_q <= dir_d;
    end
  end

  assign dr  = dr_q;
  assign idx = idx_q;
  assign rqm = rqm_q;
  assign dir = dir_q;

  // R2: a core load always leaves the flag and direction set.
  a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |=> (rqm_q && dir_q && idx_q == '0 && dr_q == $past(core_wdata)));

  // R4: a non-final byte in double mode keeps the flag.
  a_r4_mid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && dual && idx_q != LAST && !core_wr && !core_rd && rqm_q) |=> rqm_q);

  // R5: a host write in single mode lands in the low byte.
  a_r5_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !dual && !core_wr && !core_rd) |=> dr_q[BW-1:0] == $past(wr_byte));

  // R10: the flag falls only after a completed host byte.
  a_r10_fall_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rqm_q) |-> $past(rd_done || wr_done));
endmodule

// File: rtl/hpp_bus.sv
module hpp_bus
  import hpp_pkg::*;
#(
  parameter int DW = DR_W,
  parameter int BW = BUS_W,
  localparam int NBYTE = DW / BW,
  localparam int PW    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          a0,
  input  logic          dack_n,
  input  logic [DW-1:0] dr,
  input  logic [PW-1:0] idx,
  input  logic [BW-1:0] status,
  output logic [BW-1:0] dout,
  output logic          oe
);
  logic sr_sel;

  always_comb begin
    sr_sel = dack_n && !cs_n && a0;
    oe     = !rd_n && (!cs_n || !dack_n);
    if (sr_sel) dout = status;
    else        dout = dr[BW*int'(idx) +: BW];
  end

  // R9: the bus is released whenever the read strobe is high.
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !oe);
endmodule

// File: rtl/host_pport.sv
module host_pport
  import hpp_pkg::*;
#(
  parameter int DW = DR_W,
  parameter int BW = BUS_W,
  localparam int NBYTE = DW / BW,
  localparam int PW    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic          dack_n,
  inout  wire  [BW-1:0] hd,
  output logic          drq,
  input  logic          dual,
  input  logic          core_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_rd,
  output logic [DW-1:0] core_rdata,
  output logic          rqm
);
  logic          dr_rd_done, dr_wr_done, sr_done;
  logic [BW-1:0] wr_byte;
  logic [DW-1:0] dr;
  logic [PW-1:0] idx;
  logic          dir, fin;
  logic [BW-1:0] status, dout;
  logic          oe;
  logic          drq_q, drq_d;

  hpp_strobe #(.W(BW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .a0(a0), .dack_n(dack_n), .din(hd),
    .dr_rd_done(dr_rd_done), .dr_wr_done(dr_wr_done), .sr_done(sr_done),
    .wr_byte(wr_byte)
  );

  hpp_dreg #(.DW(DW), .BW(BW)) u_dreg (
    .clk(clk), .rst_n(rst_n), .dual(dual),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_rd(core_rd),
    .rd_done(dr_rd_done), .wr_done(dr_wr_done), .wr_byte(wr_byte),
    .dr(dr), .idx(idx), .rqm(rqm), .dir(dir), .fin(fin)
  );

  always_comb begin
    status          = '0;
    status[ST_RQM]  = rqm;
    status[ST_DIR]  = dir;
    status[ST_PTR]  = (idx != '0);
    status[ST_MODE] = dual;
  end

  hpp_bus #(.DW(DW), .BW(BW)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .a0(a0),
    .dack_n(dack_n), .dr(dr), .idx(idx), .status(status),
    .dout(dout), .oe(oe)
  );

  assign hd = oe ? dout : {BW{1'bz}};

  // DMA request register, kept apart from the flag.
  always_comb begin
    drq_d = drq_q;
    if (core_wr || core_rd) drq_d = 1'b1;
    else if (fin)           drq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drq_q <= 1'b0;
    else        drq_q <= drq_d;
  end

  assign drq        = drq_q;
  assign core_rdata = dr;

  // R10: the DMA request and the flag agree on every cycle.
  a_r10_drq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    drq == rqm);

  // R7: a status access leaves the data register and flag untouched.
  a_r7_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_done && !core_wr && !core_rd) |=> ($stable(core_rdata) && $stable(rqm)));
endmodule

// File: tb/test_host_pport.sv
module test_host_pport;
  localparam int OP_MODE = 0, OP_CWR = 1, OP_HRD = 2, OP_HWR = 3, OP_CRD = 4;

  typedef struct packed {
    logic [2:0]  op;
    logic        a0;
    logic        dk;
    logic [3:0]  tag;
    logic [15:0] d;
    logic [15:0] e;
  } vec_t;

  function automatic vec_t mk(input int op, input logic a0, input logic dk,
                              input int tag, input logic [15:0] d, input logic [15:0] e);
    vec_t v;
    v.op = op[2:0]; v.a0 = a0; v.dk = dk; v.tag = tag[3:0]; v.d = d; v.e = e;
    return v;
  endfunction

  localparam int NV = 32;
  // Status byte: {flag, dir, ptr!=0, mode, 4'b0}
  localparam vec_t VT [NV] = '{
    mk(OP_MODE,0,0, 4, 16'h0000, 16'h0000),
    mk(OP_CWR, 0,0, 2, 16'h12A5, 16'h0000),
    mk(OP_HRD, 1,0, 7, 16'h0000, 16'h00C0), // R2 R7 status after load
    mk(OP_HRD, 0,0, 3, 16'h0000, 16'h00A5), // R3 low byte
    mk(OP_HRD, 1,0, 3, 16'h0000, 16'h0040), // R3 flag cleared
    mk(OP_HRD, 0,0, 3, 16'h0000, 16'h00A5), // R3 single mode stays on low byte
    mk(OP_MODE,0,0, 4, 16'h0001, 16'h0000),
    mk(OP_CWR, 0,0, 4, 16'hBEEF, 16'h0000),
    mk(OP_HRD, 1,0, 7, 16'h0000, 16'h00D0), // R7 mode bit
    mk(OP_HRD, 0,0, 4, 16'h0000, 16'h00EF), // R4 first byte low
    mk(OP_HRD, 1,0, 4, 16'h0000, 16'h00F0), // R4 flag kept, ptr set
    mk(OP_HRD, 0,0, 4, 16'h0000, 16'h00BE), // R4 second byte high
    mk(OP_HRD, 1,0, 4, 16'h0000, 16'h0050), // R4 flag cleared
    mk(OP_CRD, 0,0, 6, 16'h0000, 16'hBEEF), // R6 core take
    mk(OP_HRD, 1,0, 6, 16'h0000, 16'h0090), // R6 dir 0, flag 1
    mk(OP_HWR, 0,0, 5, 16'h0034, 16'h0000),
    mk(OP_HRD, 1,0, 5, 16'h0000, 16'h00B0), // R5 flag kept after first write
    mk(OP_HWR, 0,0, 5, 16'h0056, 16'h0000),
    mk(OP_HRD, 1,0, 5, 16'h0000, 16'h0010), // R5 flag cleared after second
    mk(OP_CRD, 0,0, 5, 16'h0000, 16'h5634), // R5 byte order
    mk(OP_HWR, 1,0, 7, 16'h0077, 16'h0000), // R7 write to status
    mk(OP_HRD, 1,0, 7, 16'h0000, 16'h0090), // R7 ignored
    mk(OP_CRD, 0,0, 7, 16'h0000, 16'h5634), // R7 data untouched
    mk(OP_HWR, 1,1, 8, 16'h0011, 16'h0000), // R8 dack overrides a0
    mk(OP_HWR, 1,1, 8, 16'h0022, 16'h0000),
    mk(OP_HRD, 1,0, 8, 16'h0000, 16'h0010), // R8 transfer completed
    mk(OP_CRD, 0,0, 8, 16'h0000, 16'h2211), // R8 data via dack
    mk(OP_MODE,0,0, 8, 16'h0000, 16'h0000),
    mk(OP_CWR, 0,0, 8, 16'h0099, 16'h0000),
    mk(OP_HRD, 1,1, 8, 16'h0000, 16'h0099), // R8 dack read
    mk(OP_HRD, 1,0, 8, 16'h0000, 16'h0040), // R8 flag cleared by dack read
    mk(OP_HRD, 0,0, 3, 16'h0000, 16'h0099)
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, dack_n = 1'b1;
  logic        dual = 1'b0, core_wr = 1'b0, core_rd = 1'b0;
  logic [15:0] core_wdata = 16'h0000;
  logic [15:0] core_rdata;
  logic        drq, rqm;
  logic        tb_oe = 1'b0;
  logic [7:0]  tb_d = 8'h00;
  wire  [7:0]  hd;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  assign hd = tb_oe ? tb_d : 8'hzz;

  always #10 clk = ~clk;

  host_pport i_host_pport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .a0(a0), .dack_n(dack_n), .hd(hd), .drq(drq), .dual(dual),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_rd(core_rd),
    .core_rdata(core_rdata), .rqm(rqm)
  );

  task automatic check(input int tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic host_acc(input logic rd, input logic ad, input logic dk,
                          input logic [7:0] w, output logic [7:0] r);
    @(negedge clk);
    if (dk) dack_n = 1'b0; else cs_n = 1'b0;
    a0 = ad;
    if (rd) rd_n = 1'b0;
    else begin wr_n = 1'b0; tb_oe = 1'b1; tb_d = w; end
    @(negedge clk);
    r = hd;
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1; dack_n = 1'b1; tb_oe = 1'b0;
    @(negedge clk);
  endtask

  task automatic core_pulse(input logic ld, input logic [15:0] w);
    @(negedge clk);
    if (ld) begin core_wr = 1'b1; core_wdata = w; end
    else core_rd = 1'b1;
    @(negedge clk);
    core_wr = 1'b0; core_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, {15'd0, rqm}, 16'h0000);
    check(1, {15'd0, drq}, 16'h0000);
    check(1, core_rdata, 16'h0000);
    tb_oe = 1'b1; tb_d = 8'h00;
    #1 check(1, {8'h00, hd}, 16'h0000); // R1 bus not driven
    tb_oe = 1'b0;
    host_acc(1'b1, 1'b1, 1'b0, 8'h00, rb);
    check(1, {8'h00, rb}, 16'h0000); // R1 status all zero

    for (int i = 0; i < NV; i++) begin
      case (int'(VT[i].op))
        OP_MODE: begin @(negedge clk); dual = VT[i].d[0]; end
        OP_CWR:  core_pulse(1'b1, VT[i].d);
        OP_HRD: begin
          host_acc(1'b1, VT[i].a0, VT[i].dk, 8'h00, rb);
          check(int'(VT[i].tag), {8'h00, rb}, VT[i].e);
        end
        OP_HWR:  host_acc(1'b0, VT[i].a0, VT[i].dk, VT[i].d[7:0], rb);
        default: begin
          @(negedge clk);
          check(int'(VT[i].tag), core_rdata, VT[i].e);
          core_pulse(1'b0, 16'h0000);
        end
      endcase
    end

    // R10: drq follows the flag through a double-byte read
    @(negedge clk); dual = 1'b1;
    core_pulse(1'b1, 16'hC3A1);
    check(10, {15'd0, drq}, 16'h0001);
    host_acc(1'b1, 1'b0, 1'b1, 8'h00, rb);
    check(10, {15'd0, drq}, 16'h0001); // R10 held after first byte
    host_acc(1'b1, 1'b0, 1'b1, 8'h00, rb);
    check(10, {8'h00, rb}, 16'h00C3);
    check(10, {15'd0, drq}, 16'h0000); // R10 fell on final byte

    // R9: status driven by nothing while rd_n is high, cs low
    core_pulse(1'b1, 16'hFFFF);
    @(negedge clk); cs_n = 1'b0; a0 = 1'b1; tb_oe = 1'b1; tb_d = 8'h00;
    #1 check(9, {8'h00, hd}, 16'h0000); // R9 cs low, rd high
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    #1 check(9, {8'h00, hd}, 16'h0000); // R9 rd low, unselected
    @(negedge clk); rd_n = 1'b1; tb_oe = 1'b0;
    @(negedge clk);
    check(9, {15'd0, rqm}, 16'h0001); // R9 no transfer happened

    // R11: both strobes low together
    @(negedge clk); cs_n = 1'b0; a0 = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    check(11, {15'd0, rqm}, 16'h0001);
    check(11, core_rdata, 16'hFFFF);
    host_acc(1'b1, 1'b1, 1'b0, 8'h00, rb);
    check(11, {8'h00, rb}, 16'h00D0); // R11 pointer still zero

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule